// File: doc/BRIEF.md
# Dual-Channel Vectored Interrupt Prioritizer

This block sits between the interrupt sources of a two-channel serial controller and the processor's interrupt logic. Each channel offers four sources: receive error, receive character, external/status change and transmit buffer empty. Every clock cycle the block qualifies the pending source levels with their enables and picks one winner by a fixed priority. It then encodes the winner as a 3-bit channel/source code and, when requested, merges that code into a programmable base vector.

The block also takes part in an interrupt daisy chain. It passes the chain enable downstream only while neither channel is being serviced, and it raises a request only when the chain grants it priority. An acknowledge clears the winning source with a one-cycle strobe, marks the winner's channel in service and freezes the vector. A return-from-interrupt or an end-of-interrupt command releases the service state. A first-character receive mode limits receive requests to one character per arming.

Top module: `sio_irq_prioritizer`

## Requirements
- R1: Among qualified sources, channel 0 wins over channel 1. Within a channel, error wins over receive, receive over status and status over transmit.
- R2: An error source is always qualified. Receive needs its channel's 2-bit receive mode to be nonzero (00 off, 01 first character, 10 or 11 every character). Status needs `stat_ie[c]` and transmit needs `tx_ie[c]`. An unqualified source raises no request.
- R3: The code is {channel is 0, source}, where the source is 3 for error, 2 for receive, 1 for status and 0 for transmit.
- R4: With `vec_st_en` low, `vec_out` equals `base_vec`.
- R5: With `vec_st_en` high and `vec_ext` low, the code replaces bits 3:1 of the base. The code is 3 when nothing is pending.
- R6: With `vec_st_en` and `vec_ext` high, the code is 7 when nothing is pending. For `vec_sel` values 0, 1, 4, 5 and 7 the code replaces bits 4:2; for 2, 3 and 6 it replaces bits 2:0.
- R7: `ie_out` is `ie_in` while no channel is in service, otherwise low. `irq` is high exactly when `ie_out` is high and some source is qualified.
- R8: `iack` while `irq` is high drives the winner's clear strobe in that same cycle, with `vec_out` showing the winner's vector. The winner's channel is in service from the next cycle. `iack` while `irq` is low has no effect.
- R9: While a channel is in service, the code in `vec_out` stays at the value captured at acknowledge, whatever the sources do.
- R10: `reti` releases the lowest-numbered channel that is in service, effective the next cycle.
- R11: `eoi` releases every channel the next cycle, and it overrides an acknowledge in the same cycle.
- R12: In receive mode 01, the receive source of a channel is qualified only while that channel is armed. A channel is armed after reset and one cycle after `rx_arm[c]`. It is disarmed by acknowledging its receive source while in mode 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_err | input | 2 | Receive-error pending, one bit per channel |
| src_rx | input | 2 | Receive-character pending level per channel |
| src_stat | input | 2 | External/status-change pending per channel |
| src_tx | input | 2 | Transmit-buffer-empty pending per channel |
| rx_mode | input | 4 | Receive interrupt mode, bits 2c+1:2c for channel c |
| stat_ie | input | 2 | Status interrupt enable per channel |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| rx_arm | input | 2 | Re-arm first-character receive per channel (pulse) |
| base_vec | input | 8 | Base interrupt vector |
| vec_st_en | input | 1 | Merge the code into the vector |
| vec_ext | input | 1 | Select the extended placement scheme |
| vec_sel | input | 3 | Bit position select for the extended scheme |
| ie_in | input | 1 | Daisy-chain enable from upstream |
| iack | input | 1 | Interrupt acknowledge |
| reti | input | 1 | Return from interrupt |
| eoi | input | 1 | End-of-interrupt command |
| irq | output | 1 | Interrupt request |
| ie_out | output | 1 | Daisy-chain enable to downstream |
| vec_out | output | 8 | Vector with the code merged in |
| clr_err | output | 2 | Clear strobe for the error source per channel |
| clr_rx | output | 2 | Clear strobe for the receive source per channel |
| clr_stat | output | 2 | Clear strobe for the status source per channel |
| clr_tx | output | 2 | Clear strobe for the transmit source per channel |

## Verification
A stuck in-service flag shows at the ports in the very next cycle: `ie_out` stays low and `irq` stays dead even though a qualified source is pending. A stale held code shows as a frozen vector after release, because the bench reads `vec_out` in the first cycle after `reti`. A disarm flag that is never cleared, or never set, shows one cycle after the acknowledge or the arm pulse, as a receive request that is present when it should be gone, or missing when it should be back. Priority and placement errors show in the same cycle as the stimulus, because the code path from the sources to `vec_out` is combinational.

// File: rtl/sio_irq_pkg.sv
`timescale 1ns/1ps
package sio_irq_pkg;
    localparam int NCH    = 2;
    localparam int NSRC   = 4;
    localparam int VEC_W  = 8;
    localparam int CODE_W = 3;
    localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        SRC_TX   = 2'd0,
        SRC_STAT = 2'd1,
        SRC_RX   = 2'd2,
        SRC_ERR  = 2'd3
    } src_e;

    localparam logic [MODE_W-1:0] RXM_OFF   = 2'b00;
    localparam logic [MODE_W-1:0] RXM_FIRST = 2'b01;

    localparam logic [CODE_W-1:0] IDLE_NARROW = 3'd3;
    localparam logic [CODE_W-1:0] IDLE_WIDE   = 3'd7;

    typedef struct packed {
        logic [NCH-1:0]    in_svc;
        logic [CODE_W-1:0] held;
        logic [NCH-1:0]    armed;
    } irq_state_t;
endpackage

// File: rtl/sio_irq_arbiter.sv
`timescale 1ns/1ps
module sio_irq_arbiter
    import sio_irq_pkg::*;
(
    input  logic [NCH*NSRC-1:0] qual,
    output logic                found,
    output logic [CHW-1:0]      win_ch,
    output src_e                win_src
);
    // Scan from lowest priority up; the last hit is the winner.
    always_comb begin
        found   = 1'b0;
        win_ch  = '0;
        win_src = SRC_TX;
        for (int c = NCH - 1; c >= 0; c--) begin
            for (int s = 0; s < NSRC; s++) begin
                if (qual[c*NSRC + s]) begin
                    found   = 1'b1;
                    win_ch  = CHW'(c);
                    win_src = src_e'(s);
                end
            end
        end
    end
endmodule

// File: rtl/sio_irq_vecfmt.sv
`timescale 1ns/1ps
module sio_irq_vecfmt
    import sio_irq_pkg::*;
(
    input  logic [VEC_W-1:0]  base,
    input  logic [CODE_W-1:0] code,
    input  logic              st_en,
    input  logic              ext,
    input  logic [2:0]        sel,
    output logic [VEC_W-1:0]  vec
);
    logic high_slot;

    always_comb begin
        high_slot = (sel == 3'd0) || (sel == 3'd1) || (sel == 3'd4) ||
                    (sel == 3'd5) || (sel == 3'd7);
        vec = base;
        if (st_en) begin
            if (!ext)
                vec[3:1] = code;
            else if (high_slot)
                vec[4:2] = code;
            else
                vec[2:0] = code;
        end
    end
endmodule

// File: rtl/sio_irq_prioritizer.sv
`timescale 1ns/1ps
module sio_irq_prioritizer
    import sio_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        src_err,
    input  logic [NCH-1:0]        src_rx,
    input  logic [NCH-1:0]        src_stat,
    input  logic [NCH-1:0]        src_tx,
    input  logic [NCH*MODE_W-1:0] rx_mode,
    input  logic [NCH-1:0]        stat_ie,
    input  logic [NCH-1:0]        tx_ie,
    input  logic [NCH-1:0]        rx_arm,
    input  logic [VEC_W-1:0]      base_vec,
    input  logic                  vec_st_en,
    input  logic                  vec_ext,
    input  logic [2:0]            vec_sel,
    input  logic                  ie_in,
    input  logic                  iack,
    input  logic                  reti,
    input  logic                  eoi,
    output logic                  irq,
    output logic                  ie_out,
    output logic [VEC_W-1:0]      vec_out,
    output logic [NCH-1:0]        clr_err,
    output logic [NCH-1:0]        clr_rx,
    output logic [NCH-1:0]        clr_stat,
    output logic [NCH-1:0]        clr_tx
);
    irq_state_t q, d;

    logic [NCH*NSRC-1:0] qual;
    logic                found;
    logic [CHW-1:0]      win_ch;
    src_e                win_src;
    logic                any_svc;
    logic                grant;
    logic [CODE_W-1:0]   code_now;
    logic [CODE_W-1:0]   code_shown;

    // Qualification of each source (R2, R12)
    for (genvar c = 0; c < NCH; c++) begin : g_qual
        logic [MODE_W-1:0] mode_c;
        assign mode_c = rx_mode[c*MODE_W +: MODE_W];
        assign qual[c*NSRC + int'(SRC_ERR)]  = src_err[c];
        assign qual[c*NSRC + int'(SRC_RX)]   = src_rx[c] && (mode_c != RXM_OFF) &&
                                               ((mode_c != RXM_FIRST) || q.armed[c]);
        assign qual[c*NSRC + int'(SRC_STAT)] = src_stat[c] && stat_ie[c];
        assign qual[c*NSRC + int'(SRC_TX)]   = src_tx[c] && tx_ie[c];

        assign clr_err[c]  = grant && (win_ch == CHW'(c)) && (win_src == SRC_ERR);
        assign clr_rx[c]   = grant && (win_ch == CHW'(c)) && (win_src == SRC_RX);
        assign clr_stat[c] = grant && (win_ch == CHW'(c)) && (win_src == SRC_STAT);
        assign clr_tx[c]   = grant && (win_ch == CHW'(c)) && (win_src == SRC_TX);

        a_r2_rx_clear_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
            clr_rx[c] |-> (mode_c != RXM_OFF));
    end

    sio_irq_arbiter u_arb (
        .qual    (qual),
        .found   (found),
        .win_ch  (win_ch),
        .win_src (win_src)
    );

    assign any_svc    = |q.in_svc;
    assign ie_out     = ie_in && !any_svc;
    assign irq        = ie_out && found;
    assign grant      = iack && irq;
    assign code_now   = found ? {win_ch == CHW'(0), win_src} :
                                (vec_ext ? IDLE_WIDE : IDLE_NARROW);
    assign code_shown = any_svc ? q.held : code_now;

    sio_irq_vecfmt u_fmt (
        .base  (base_vec),
        .code  (code_shown),
        .st_en (vec_st_en),
        .ext   (vec_ext),
        .sel   (vec_sel),
        .vec   (vec_out)
    );

    always_comb begin
        logic released;
        d        = q;
        released = 1'b0;
        if (reti) begin
            for (int c = 0; c < NCH; c++) begin
                if (!released && q.in_svc[c]) begin
                    d.in_svc[c] = 1'b0;
                    released    = 1'b1;
                end
            end
        end
        if (grant) begin
            d.in_svc[win_ch] = 1'b1;
            d.held           = code_now;
            if (win_src == SRC_RX && rx_mode[win_ch*MODE_W +: MODE_W] == RXM_FIRST)
                d.armed[win_ch] = 1'b0;
        end
        d.armed = d.armed | rx_arm;
        if (eoi)
            d.in_svc = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.in_svc <= '0;
            q.held   <= IDLE_NARROW;
            q.armed  <= '1;
        end else begin
            q <= d;
        end
    end

    a_r7_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        any_svc |-> (!irq && !ie_out));

    a_r8_grant_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && irq && !eoi) |=> any_svc);

    a_r8_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_err, clr_rx, clr_stat, clr_tx}));

    a_r11_eoi_releases: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> !any_svc);

    a_r9_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
        (any_svc && $past(any_svc) && $stable(base_vec) && $stable(vec_st_en) &&
         $stable(vec_ext) && $stable(vec_sel)) |-> $stable(vec_out));
endmodule

// File: tb/tb_sio_irq_prioritizer.sv
`timescale 1ns/1ps
module tb_sio_irq_prioritizer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_err = '0, src_rx = '0, src_stat = '0, src_tx = '0;
    logic [3:0] rx_mode = '0;
    logic [1:0] stat_ie = '0, tx_ie = '0, rx_arm = '0;
    logic [7:0] base_vec = 8'hA5;
    logic       vec_st_en = 1'b0, vec_ext = 1'b0;
    logic [2:0] vec_sel = '0;
    logic       ie_in = 1'b1, iack = 1'b0, reti = 1'b0, eoi = 1'b0;
    logic       irq, ie_out;
    logic [7:0] vec_out;
    logic [1:0] clr_err, clr_rx, clr_stat, clr_tx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sio_irq_prioritizer dut (
        .clk(clk), .rst_n(rst_n),
        .src_err(src_err), .src_rx(src_rx), .src_stat(src_stat), .src_tx(src_tx),
        .rx_mode(rx_mode), .stat_ie(stat_ie), .tx_ie(tx_ie), .rx_arm(rx_arm),
        .base_vec(base_vec), .vec_st_en(vec_st_en), .vec_ext(vec_ext), .vec_sel(vec_sel),
        .ie_in(ie_in), .iack(iack), .reti(reti), .eoi(eoi),
        .irq(irq), .ie_out(ie_out), .vec_out(vec_out),
        .clr_err(clr_err), .clr_rx(clr_rx), .clr_stat(clr_stat), .clr_tx(clr_tx)
    );

    function automatic logic [7:0] exp_vec(input logic [7:0] b, input logic [2:0] code,
                                           input logic st, input logic ext,
                                           input logic [2:0] sel);
        logic [7:0] cw;
        cw = {5'b0, code};
        if (!st) return b;
        if (!ext) return (b & 8'hF1) | (cw << 1);
        if (sel inside {3'd0, 3'd1, 3'd4, 3'd5, 3'd7}) return (b & 8'hE3) | (cw << 2);
        return (b & 8'hF8) | cw;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edge_in();
        @(negedge clk);
    endtask

    task automatic quiet();
        edge_in();
        src_err = '0; src_rx = '0; src_stat = '0; src_tx = '0;
        stat_ie = '0; tx_ie = '0; rx_mode = '0; ie_in = 1'b1;
        iack = 0; reti = 0; eoi = 0; rx_arm = '0;
    endtask

    task automatic t_reset();
        #1;
        chk("R7 irq idle after reset", irq, 0);
        chk("R7 ie_out passes chain", ie_out, 1);
        chk("R4 vector is base", vec_out, 8'hA5);
        chk("R8 no strobes idle", {clr_err, clr_rx, clr_stat, clr_tx}, 0);
    endtask

    task automatic t_priority();
        quiet();
        base_vec = 8'hA1; vec_st_en = 1; vec_ext = 0;
        src_err = 2'b10; src_rx = 2'b01; rx_mode = 4'b0010;
        src_stat = 2'b01; stat_ie = 2'b01;
        #1;
        chk("R1 ch0 rx beats ch1 err", vec_out, exp_vec(8'hA1, 3'd6, 1, 0, 0));
        chk("R7 irq raised", irq, 1);
        edge_in(); src_rx = 2'b00; #1;
        chk("R3 ch0 status code 5", vec_out, exp_vec(8'hA1, 3'd5, 1, 0, 0));
        edge_in(); src_stat = 2'b00; #1;
        chk("R3 ch1 error code 3 R5", vec_out, exp_vec(8'hA1, 3'd3, 1, 0, 0));
        edge_in(); src_err = 2'b11; src_tx = 2'b01; tx_ie = 2'b01; #1;
        chk("R1 ch0 error first", vec_out, exp_vec(8'hA1, 3'd7, 1, 0, 0));
    endtask

    task automatic t_enables();
        quiet();
        base_vec = 8'h00; vec_st_en = 1; vec_ext = 0;
        src_tx = 2'b10; #1;
        chk("R2 tx without enable", irq, 0);
        edge_in(); tx_ie = 2'b10; #1;
        chk("R2 tx enabled", irq, 1);
        chk("R3 ch1 tx code 0", vec_out, 8'h00);
        edge_in(); src_tx = 0; tx_ie = 0; src_stat = 2'b01; #1;
        chk("R2 status without enable", irq, 0);
        edge_in(); src_stat = 0; src_rx = 2'b10; #1;
        chk("R2 rx with mode off", irq, 0);
        edge_in(); rx_mode = 4'b1100; #1;
        chk("R2 rx every-char mode", irq, 1);
        chk("R3 ch1 rx code 2", vec_out, exp_vec(8'h00, 3'd2, 1, 0, 0));
        edge_in(); src_rx = 0; rx_mode = 0; src_err = 2'b01; #1;
        chk("R2 error needs no enable", vec_out, exp_vec(8'h00, 3'd7, 1, 0, 0));
    endtask

    task automatic t_vecmodes();
        quiet();
        base_vec = 8'h00; vec_st_en = 1; vec_ext = 1; vec_sel = 3'd0; #1;
        chk("R6 idle code 7 high slot", vec_out, 8'h1C);
        edge_in(); vec_sel = 3'd2; #1;
        chk("R6 idle code 7 low slot", vec_out, 8'h07);
        edge_in(); vec_ext = 0; #1;
        chk("R5 idle code 3", vec_out, 8'h06);
        edge_in(); vec_st_en = 0; base_vec = 8'h5A; #1;
        chk("R4 status off passes base", vec_out, 8'h5A);
        edge_in(); vec_st_en = 1; vec_ext = 1; base_vec = 8'h00; vec_sel = 3'd5;
        src_tx = 2'b01; tx_ie = 2'b01; #1;
        chk("R6 sel 5 high slot", vec_out, 8'h10);
        edge_in(); vec_sel = 3'd6; #1;
        chk("R6 sel 6 low slot", vec_out, 8'h04);
        edge_in(); base_vec = 8'hFF; #1;
        chk("R6 sel 6 keeps base bits", vec_out, 8'hFC);
        edge_in(); vec_sel = 3'd7; #1;
        chk("R6 sel 7 keeps base bits", vec_out, 8'hF3);
    endtask

    task automatic t_ack();
        quiet();
        base_vec = 8'h40; vec_st_en = 1; vec_ext = 1; vec_sel = 3'd3;
        src_stat = 2'b10; stat_ie = 2'b10; #1;
        chk("R3 ch1 status vector", vec_out, 8'h41);
        edge_in(); iack = 1; #1;
        chk("R8 status strobe ch1", {clr_err, clr_rx, clr_stat, clr_tx}, 8'b00_00_10_00);
        chk("R8 vector during ack", vec_out, 8'h41);
        edge_in(); iack = 0; src_stat = 0; src_err = 2'b01; #1;
        chk("R7 no irq in service", irq, 0);
        chk("R7 chain blocked", ie_out, 0);
        chk("R9 vector held", vec_out, 8'h41);
        edge_in(); reti = 1; #1;
        edge_in(); reti = 0; #1;
        chk("R10 released irq", irq, 1);
        chk("R10 fresh vector", vec_out, 8'h47);
    endtask

    task automatic t_ignored();
        quiet();
        src_tx = 2'b01; tx_ie = 2'b01; ie_in = 0; #1;
        chk("R7 chain low no irq", irq, 0);
        chk("R7 chain low ie_out", ie_out, 0);
        iack = 1; #1;
        chk("R8 ack ignored no strobe", clr_tx, 0);
        edge_in(); iack = 0; ie_in = 1; #1;
        chk("R8 ack ignored not in service", irq, 1);
    endtask

    task automatic t_eoi();
        quiet();
        src_err = 2'b10;
        edge_in(); iack = 1;
        edge_in(); iack = 0; #1;
        chk("R8 in service after ack", ie_out, 0);
        edge_in(); eoi = 1;
        edge_in(); eoi = 0; #1;
        chk("R11 eoi releases", ie_out, 1);
        edge_in(); iack = 1; eoi = 1; #1;
        chk("R8 strobe with eoi", clr_err, 2'b10);
        edge_in(); iack = 0; eoi = 0; #1;
        chk("R11 eoi beats ack", ie_out, 1);
    endtask

    task automatic t_firstchar();
        quiet();
        rx_mode = 4'b0001; src_rx = 2'b01; #1;
        chk("R12 armed from reset", irq, 1);
        edge_in(); iack = 1; #1;
        chk("R12 rx strobe ch0", clr_rx, 2'b01);
        edge_in(); iack = 0; reti = 1;
        edge_in(); reti = 0; #1;
        chk("R12 disarmed after ack", irq, 0);
        chk("R12 chain open while disarmed", ie_out, 1);
        edge_in(); rx_arm = 2'b01; #1;
        chk("R12 arm takes a cycle", irq, 0);
        edge_in(); rx_arm = 0; #1;
        chk("R12 rearmed", irq, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_priority();
        t_enables();
        t_vecmodes();
        t_ack();
        t_ignored();
        t_eoi();
        t_firstchar();
        quiet();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule